// File: doc/BRIEF.md
# Split Transmit/Receive Word FIFO

This block keeps one RAM of 32-bit words and carves it into two circular queues: a transmit queue in the low words and a receive queue in the high words. A software register sets the first word of the receive queue. Everything below that word belongs to transmit, and everything from it up to the top word belongs to receive. A second register is read-only and reports the top valid word, so software can choose a split.

The transmit side also decides when a frame may start. A 2-bit code picks a byte threshold. The start-allowed output rises when the bytes queued reach that threshold, or as soon as a word tagged as the end of a frame is in the queue. Moving the split discards the contents of both queues, so no word is left on the wrong side of the boundary.

Top module: `shared_fifo_split`

## Requirements
- R1: After reset the split register reads 0x0000_01FC (word 127, half of the top word 255), the watermark register reads 0, both queues are empty, both error flags are low and tx_start_ok is low.
- R2: Register address 1 is read-only and reads 0x0020_03FC: the top word index 255 in bits [9:2] and bit 21 set. Writes to it change nothing.
- R3: Register address 0 holds the split as a byte address. Bits [9:2] are stored and all other bits read 0. A written word index of 0 is stored as 1, so it reads back as 0x0000_0004.
- R4: The transmit queue holds exactly (split word index) words in first-in first-out order. It wraps from the word just below the split back to word 0, and tx_full rises when it holds that many words.
- R5: The receive queue holds exactly (256 − split word index) words in first-in first-out order. It wraps from word 255 back to the split word, and rx_full rises when it holds that many words.
- R6: When both queues are filled completely, the contents of each are read back intact.
- R7: A write to register address 0 empties both queues and clears both error flags. Any queue push or pop in that same cycle is dropped.
- R8: Watermark register address 2, bits [1:0]: codes 00 and 01 mean 64 bytes (16 words), 10 means 128 bytes (32 words) and 11 means 192 bytes (48 words). tx_start_ok is high once the transmit queue holds at least that many words.
- R9: A transmit word written with tx_wlast = 1 raises tx_start_ok below the watermark. tx_rlast shows that flag on the head word. Once that word is popped and no other tagged word remains, the early start ends.
- R10: A push into a full queue is dropped and sets that queue's error flag, which stays set until the next split write.
- R11: A pop from an empty queue is dropped and sets that queue's error flag.
- R12: Only bits [1:0] of the watermark register are stored. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 split, 1 top word, 2 watermark |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_wr | input | 1 | Push a word into the transmit queue |
| tx_wdata | input | 32 | Transmit word to push |
| tx_wlast | input | 1 | Word being pushed ends a frame |
| tx_full | output | 1 | Transmit queue full |
| tx_rd | input | 1 | Pop the transmit head word |
| tx_rdata | output | 32 | Transmit head word |
| tx_rlast | output | 1 | Head word ends a frame |
| tx_empty | output | 1 | Transmit queue empty |
| tx_start_ok | output | 1 | Frame transmission may begin |
| tx_err | output | 1 | Sticky transmit overflow/underflow flag |
| rx_wr | input | 1 | Push a word into the receive queue |
| rx_wdata | input | 32 | Receive word to push |
| rx_full | output | 1 | Receive queue full |
| rx_rd | input | 1 | Pop the receive head word |
| rx_rdata | output | 32 | Receive head word |
| rx_empty | output | 1 | Receive queue empty |
| rx_err | output | 1 | Sticky receive overflow/underflow flag |

## Verification
The start decision is tried with each of the four watermark codes. For each code the bench stops one word short of the threshold and then adds the word that meets it, which separates the codes and exposes an off-by-one in the threshold. The queues are tried with a small transmit region, then a small receive region, so that both wrap paths run and a wrong wrap target shows up as misordered data. Both regions are then filled together to show that neither side writes into the other. A tagged short frame shows the end-marker path apart from the byte count.

// File: rtl/shared_fifo_split.sv
module shared_fifo_split #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_wlast,
  output logic          tx_full,
  input  logic          tx_rd,
  output logic [DW-1:0] tx_rdata,
  output logic          tx_rlast,
  output logic          tx_empty,
  output logic          tx_start_ok,
  output logic          tx_err,
  input  logic          rx_wr,
  input  logic [DW-1:0] rx_wdata,
  output logic          rx_full,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rdata,
  output logic          rx_empty,
  output logic          rx_err
);
  localparam int WORDS = 1 << AW;
  localparam logic [AW-1:0] TOP = '1;
  localparam logic [AW-1:0] RST_SPLIT = TOP >> 1;
  localparam logic [31:0] TOP_REG = 32'h0020_0000 | (32'(TOP) << 2);

  logic [DW:0]   mem [WORDS];
  logic [AW-1:0] split_q;
  logic [1:0]    wm_q;
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]   tx_cnt, rx_cnt, eof_cnt;

  wire          split_wr = reg_wr && reg_addr == 2'd0;
  wire [AW-1:0] split_in = reg_wdata[AW+1:2];
  wire [AW-1:0] split_nx = (split_in == '0) ? AW'(1) : split_in;
  wire [AW:0]   tx_size  = {1'b0, split_q};
  wire [AW:0]   rx_size  = (AW+1)'(WORDS) - tx_size;

  assign tx_full  = tx_cnt == tx_size;
  assign rx_full  = rx_cnt == rx_size;
  assign tx_empty = tx_cnt == '0;
  assign rx_empty = rx_cnt == '0;

  wire tx_push = tx_wr && !tx_full  && !split_wr;
  wire tx_pop  = tx_rd && !tx_empty && !split_wr;
  wire rx_push = rx_wr && !rx_full  && !split_wr;
  wire rx_pop  = rx_rd && !rx_empty && !split_wr;

  wire [AW-1:0] tx_last_w = split_q - AW'(1);
  wire [AW-1:0] tx_wp_nx = (tx_wp == tx_last_w) ? '0 : tx_wp + AW'(1);
  wire [AW-1:0] tx_rp_nx = (tx_rp == tx_last_w) ? '0 : tx_rp + AW'(1);
  wire [AW-1:0] rx_wp_nx = (rx_wp == TOP) ? split_q : rx_wp + AW'(1);
  wire [AW-1:0] rx_rp_nx = (rx_rp == TOP) ? split_q : rx_rp + AW'(1);

  assign tx_rdata = mem[tx_rp][DW-1:0];
  assign tx_rlast = mem[tx_rp][DW];
  assign rx_rdata = mem[rx_rp][DW-1:0];

  wire [AW:0] thr = (wm_q == 2'b11) ? (AW+1)'(48) :
                    (wm_q == 2'b10) ? (AW+1)'(32) : (AW+1)'(16);
  assign tx_start_ok = !tx_empty && (tx_cnt >= thr || eof_cnt != '0);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(split_q) << 2;
      2'd1:    reg_rdata = TOP_REG;
      2'd2:    reg_rdata = {30'b0, wm_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tx_push) mem[tx_wp] <= {tx_wlast, tx_wdata};
    if (rx_push) mem[rx_wp] <= {1'b0, rx_wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_q <= RST_SPLIT;
      wm_q    <= '0;
      tx_wp   <= '0;
      tx_rp   <= '0;
      rx_wp   <= RST_SPLIT;
      rx_rp   <= RST_SPLIT;
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      eof_cnt <= '0;
      tx_err  <= 1'b0;
      rx_err  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 2'd2) wm_q <= reg_wdata[1:0];
      if (split_wr) begin
        split_q <= split_nx;
        tx_wp   <= '0;
        tx_rp   <= '0;
        rx_wp   <= split_nx;
        rx_rp   <= split_nx;
        tx_cnt  <= '0;
        rx_cnt  <= '0;
        eof_cnt <= '0;
        tx_err  <= 1'b0;
        rx_err  <= 1'b0;
      end else begin
        if (tx_push) tx_wp <= tx_wp_nx;
        if (tx_pop)  tx_rp <= tx_rp_nx;
        if (rx_push) rx_wp <= rx_wp_nx;
        if (rx_pop)  rx_rp <= rx_rp_nx;
        tx_cnt  <= tx_cnt + (AW+1)'(tx_push) - (AW+1)'(tx_pop);
        rx_cnt  <= rx_cnt + (AW+1)'(rx_push) - (AW+1)'(rx_pop);
        eof_cnt <= eof_cnt + (AW+1)'(tx_push && tx_wlast) - (AW+1)'(tx_pop && tx_rlast);
        tx_err  <= tx_err | (tx_wr && tx_full) | (tx_rd && tx_empty);
        rx_err  <= rx_err | (rx_wr && rx_full) | (rx_rd && rx_empty);
      end
    end
  end
endmodule

// File: rtl/shared_fifo_split_chk.sv
module shared_fifo_split_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        tx_wr,
  input logic        tx_rd,
  input logic        tx_full,
  input logic        tx_empty,
  input logic        tx_start_ok,
  input logic        tx_err,
  input logic        rx_wr,
  input logic        rx_rd,
  input logic        rx_full,
  input logic        rx_empty,
  input logic        rx_err
);
  wire split_wr = reg_wr && reg_addr == 2'd0;

  assert_top_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd1 |-> reg_rdata[21] && reg_rdata[31:22] == '0 && reg_rdata[1:0] == '0);
  assert_tx_full_not_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_empty);
  assert_rx_full_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_empty);
  assert_split_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    split_wr |=> tx_empty && rx_empty && !tx_err && !rx_err);
  assert_start_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_ok |-> !tx_empty);
  assert_tx_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && tx_wr && !tx_rd && !split_wr |=> tx_full && tx_err);
  assert_rx_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && rx_wr && !rx_rd && !split_wr |=> rx_full && rx_err);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err && !split_wr |=> tx_err);
  assert_tx_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty && tx_rd && !tx_wr && !split_wr |=> tx_empty && tx_err);
  assert_rx_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && rx_rd && !rx_wr && !split_wr |=> rx_empty && rx_err);
endmodule

bind shared_fifo_split shared_fifo_split_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .tx_wr(tx_wr), .tx_rd(tx_rd), .tx_full(tx_full), .tx_empty(tx_empty),
  .tx_start_ok(tx_start_ok), .tx_err(tx_err), .rx_wr(rx_wr), .rx_rd(rx_rd),
  .rx_full(rx_full), .rx_empty(rx_empty), .rx_err(rx_err)
);

// File: tb/test_shared_fifo_split.sv
module test_shared_fifo_split;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, tx_wr = 0, tx_wlast = 0, tx_rd = 0, rx_wr = 0, rx_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, tx_wdata = 0, rx_wdata = 0;
  logic [31:0] reg_rdata, tx_rdata, rx_rdata;
  logic tx_full, tx_rlast, tx_empty, tx_start_ok, tx_err, rx_full, rx_empty, rx_err;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  shared_fifo_split i_shared_fifo_split (.*);

  // code in [7:6], threshold in words in [5:0]
  localparam logic [7:0] WM_TAB [4] = '{8'h10, 8'h50, 8'hA0, 8'hF0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic tx_push(input logic [31:0] d, input logic last);
    @(negedge clk); tx_wr = 1; tx_wdata = d; tx_wlast = last;
    @(negedge clk); tx_wr = 0; tx_wlast = 0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    @(negedge clk); rx_wr = 1; rx_wdata = d;
    @(negedge clk); rx_wr = 0;
  endtask

  task automatic tx_pop(input string tag, input logic [31:0] exp);
    @(negedge clk); check(tag, tx_rdata, exp); tx_rd = 1;
    @(negedge clk); tx_rd = 0;
  endtask

  task automatic rx_pop(input string tag, input logic [31:0] exp);
    @(negedge clk); check(tag, rx_rdata, exp); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    reg_read(2'd0, v); check("R1 split", v, 32'h1FC);
    reg_read(2'd2, v); check("R1 wm", v, 0);
    check("R1 empty", {tx_empty, rx_empty, tx_err, rx_err, tx_start_ok}, 5'b11000);
    // R2 top word register
    reg_read(2'd1, v); check("R2 top", v, 32'h0020_03FC);
    reg_write(2'd1, 32'h0);
    reg_read(2'd1, v); check("R2 write ignored", v, 32'h0020_03FC);
    reg_read(2'd0, v); check("R2 split intact", v, 32'h1FC);

    // R8 watermark table
    for (int i = 0; i < 4; i++) begin
      reg_write(2'd0, 32'h1FC);
      reg_write(2'd2, 32'(WM_TAB[i][7:6]));
      for (int k = 0; k < WM_TAB[i][5:0] - 1; k++) tx_push(32'h100 * i + k, 0);
      check($sformatf("R8 below code %0d", i), 32'(tx_start_ok), 0);
      tx_push(32'hFF, 0);
      check($sformatf("R8 at code %0d", i), 32'(tx_start_ok), 1);
    end

    // R12
    reg_write(2'd2, 32'hFFFF_FFFE);
    reg_read(2'd2, v); check("R12 wm bits", v, 32'h2);
    reg_write(2'd2, 32'h0);

    // R3
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_read(2'd0, v); check("R3 mask", v, 32'h3FC);
    reg_write(2'd0, 32'h0);
    reg_read(2'd0, v); check("R3 zero clamp", v, 32'h4);

    // R4 small transmit region of 4 words, wrap
    reg_write(2'd0, 32'h10);
    for (int k = 0; k < 4; k++) tx_push(32'hA0 + k, 0);
    check("R4 full", 32'(tx_full), 1);
    tx_push(32'hDEAD, 0);
    check("R10 tx overflow err", {tx_full, tx_err}, 2'b11);
    tx_pop("R4 order", 32'hA0);
    tx_pop("R4 order", 32'hA1);
    tx_push(32'hA4, 0); tx_push(32'hA5, 0);
    check("R4 full after wrap", 32'(tx_full), 1);
    for (int k = 2; k < 6; k++) tx_pop("R4 wrap order", 32'hA0 + k);
    check("R4 empty", 32'(tx_empty), 1);
    check("R10 err sticky", 32'(tx_err), 1);

    // R7 split write clears
    rx_push(32'h55);
    reg_write(2'd0, 32'h10);
    check("R7 cleared", {tx_empty, rx_empty, tx_err, rx_err}, 4'b1100);
    // R11
    @(negedge clk); tx_rd = 1; @(negedge clk); tx_rd = 0;
    check("R11 tx underflow", {tx_empty, tx_err}, 2'b11);
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
    check("R11 rx underflow", {rx_empty, rx_err}, 2'b11);

    // R5 small receive region (words 252..255), wrap
    reg_write(2'd0, 32'h3F0);
    for (int k = 0; k < 4; k++) rx_push(32'hB0 + k);
    check("R5 full", 32'(rx_full), 1);
    rx_push(32'hBEEF);
    check("R10 rx overflow err", {rx_full, rx_err}, 2'b11);
    rx_pop("R5 order", 32'hB0);
    rx_pop("R5 order", 32'hB1);
    rx_push(32'hB4); rx_push(32'hB5);
    for (int k = 2; k < 6; k++) rx_pop("R5 wrap order", 32'hB0 + k);
    check("R5 empty", 32'(rx_empty), 1);

    // R6 both regions full at default split
    reg_write(2'd0, 32'h1FC);
    for (int k = 0; k < 127; k++) tx_push(32'hC000 + k, 0);
    for (int k = 0; k < 129; k++) rx_push(32'hD000 + k);
    check("R6 both full", {tx_full, rx_full, tx_err, rx_err}, 4'b1100);
    for (int k = 0; k < 127; k++) tx_pop("R6 tx data", 32'hC000 + k);
    for (int k = 0; k < 129; k++) rx_pop("R6 rx data", 32'hD000 + k);

    // R9 end marker
    reg_write(2'd0, 32'h1FC);
    tx_push(32'hE0, 0); tx_push(32'hE1, 0);
    check("R9 before marker", 32'(tx_start_ok), 0);
    tx_push(32'hE2, 1);
    check("R9 marker start", 32'(tx_start_ok), 1);
    check("R9 head not last", 32'(tx_rlast), 0);
    tx_pop("R9 data", 32'hE0); tx_pop("R9 data", 32'hE1);
    check("R9 head last", 32'(tx_rlast), 1);
    tx_pop("R9 data", 32'hE2);
    check("R9 start ends", {tx_start_ok, tx_empty}, 2'b01);

    finish_run();
  end
endmodule